// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Controller

This block is the interrupt control unit of a small 8-bit microcontroller core. It captures request flags from three core sources: an edge on an external pin, a change on an input port, and a timer overflow pulse. A group of peripheral requests arrives as flag/enable pairs from the peripherals. That group passes through a second-level group enable. Software reads and writes one 8-bit control/status register.

When a request is enabled and globally allowed, the block raises `irq_o`. In the next cycle it takes the interrupt. It pulses a vector request carrying a fixed target address, asks the core to push the return address, and clears the global enable. A return-from-interrupt strobe from the core sets the global enable again. Some writes clear the global enable while a request is already queued for the next cycle. After such a write the queued request is dropped and the core is told to run a NOP. The flag stays pending and is taken later.

Register layout (bit: meaning): 7 global enable, 6 peripheral group enable, 5 timer enable, 4 pin enable, 3 port-change enable, 2 timer flag, 1 pin flag, 0 port-change flag.

Top module: `ic_ctrl`

## Requirements
- R1: After reset, the register reads 0x00 and `irq_o`, `vec_req_o`, `push_ret_o` and `nop_o` are all 0.
- R2: A register write stores all eight bits, and the read port returns them in the layout given above.
- R3: A source flag sets on its event even when its own enable and the global enable (bit 7) are both clear.
- R4: A rising edge on `pin_i` sets bit 1. Any bit of `port_i` changing from its previous cycle value sets bit 0. A high cycle on `tmr_ovf_i` sets bit 2.
- R5: `irq_o` is bit 7 ANDed with the OR of: bit5&bit2, bit4&bit1, bit3&bit0, and bit 6 ANDed with any peripheral pair that has both flag and enable high.
- R6: One cycle after `irq_o` is high, `vec_req_o` and `push_ret_o` pulse for exactly one cycle with `vec_addr_o` = 0x0004. After that pulse, bit 7 reads 0.
- R7: Taking an interrupt leaves the source flag set. Once bit 7 is set again, the same source is taken again.
- R8: A cycle with `retfie_i` high and no take sets bit 7.
- R9: A write that clears bit 7 raises `nop_o` in the next cycle. That cycle has no take, even if a request was queued. The flag stays set and is taken after bit 7 is set again.
- R10: A hardware event in the same cycle as a write that clears its flag leaves the flag set.
- R11: With bit 6 clear, peripheral flag/enable pairs cannot raise `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | External pin level |
| port_i | input | PORT_W | Watched input port |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| periph_flag_i | input | NPER | Peripheral request flags |
| periph_en_i | input | NPER | Peripheral individual enables |
| csr_we_i | input | 1 | Register write strobe |
| csr_wdata_i | input | 8 | Register write data |
| csr_rdata_o | output | 8 | Register read data |
| retfie_i | input | 1 | Return-from-interrupt executed |
| irq_o | output | 1 | Enabled request present |
| vec_req_o | output | 1 | Interrupt taken, jump to vector |
| push_ret_o | output | 1 | Push return address |
| vec_addr_o | output | ADDR_W | Vector target address |
| nop_o | output | 1 | Core executes a NOP this cycle |

## Verification
A table of register settings and peripheral flag/enable patterns drives `irq_o`. The table separates the following cases: masked flags, unmasked flags with no global enable, mismatched flag/enable pairs (enable on one source, flag on another), and the peripheral group with its group enable on and off. Directed sequences follow. One runs the take/return loop to show that a flag left set fires again. Another clears the global enable one cycle after a request appears, to show the drop, the NOP and the later take. Another lands a timer event on a clearing write to show which of the two wins. Port and pin patterns show which kinds of edge set the flags.

// File: rtl/ic_pkg.sv
package ic_pkg;
  localparam int CSR_W    = 8;
  localparam int NSRC     = 3;
  localparam int GIE_BIT  = 7;
  localparam int PEIE_BIT = 6;
  localparam int EN_LSB   = 3;
  localparam int FLG_LSB  = 0;

  typedef enum logic [1:0] {
    SRC_PORT = 2'd0,
    SRC_PIN  = 2'd1,
    SRC_TMR  = 2'd2
  } src_e;
endpackage

// File: rtl/ic_edge_detect.sv
module ic_edge_detect #(
  parameter int PORT_W   = 4,
  parameter bit PIN_RISE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic [PORT_W-1:0] port_i,
  output logic              pin_evt_o,
  output logic              port_evt_o
);
  logic              pin_q;
  logic [PORT_W-1:0] port_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q  <= 1'b0;
      port_q <= '0;
    end else begin
      pin_q  <= pin_i;
      port_q <= port_i;
    end
  end

  generate
    if (PIN_RISE) begin : g_rise
      assign pin_evt_o = pin_i & ~pin_q;
    end else begin : g_fall
      assign pin_evt_o = ~pin_i & pin_q;
    end
  endgenerate

  assign port_evt_o = |(port_i ^ port_q);
endmodule

// File: rtl/ic_flag_bank.sv
module ic_flag_bank
  import ic_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] evt_i,
  input  logic            we_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] flg_o
);
  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_flag
      logic flg_q;
      // hardware set beats a clearing write
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       flg_q <= 1'b0;
        else if (evt_i[i]) flg_q <= 1'b1;
        else if (we_i)     flg_q <= wdata_i[i];
      end
      assign flg_o[i] = flg_q;
    end
  endgenerate
endmodule

// File: rtl/ic_accept.sv
module ic_accept (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic we_i,
  input  logic wgie_i,
  input  logic retfie_i,
  output logic gie_o,
  output logic take_o,
  output logic nop_o
);
  logic gie_q, pend_q, blk_q;

  assign take_o = pend_q & ~blk_q;
  assign nop_o  = blk_q;
  assign gie_o  = gie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q  <= 1'b0;
      pend_q <= 1'b0;
      blk_q  <= 1'b0;
    end else begin
      if (take_o)        gie_q <= 1'b0;
      else if (retfie_i) gie_q <= 1'b1;
      else if (we_i)     gie_q <= wgie_i;
      pend_q <= req_i & ~take_o;
      blk_q  <= we_i & ~wgie_i;
    end
  end
endmodule

// File: rtl/ic_ctrl.sv
module ic_ctrl
  import ic_pkg::*;
#(
  parameter int              PORT_W   = 4,
  parameter int              NPER     = 4,
  parameter int              ADDR_W   = 13,
  parameter bit              PIN_RISE = 1'b1,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 13'h0004
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic              tmr_ovf_i,
  input  logic [NPER-1:0]   periph_flag_i,
  input  logic [NPER-1:0]   periph_en_i,
  input  logic              csr_we_i,
  input  logic [CSR_W-1:0]  csr_wdata_i,
  output logic [CSR_W-1:0]  csr_rdata_o,
  input  logic              retfie_i,
  output logic              irq_o,
  output logic              vec_req_o,
  output logic              push_ret_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              nop_o
);
  logic            pin_evt, port_evt;
  logic [NSRC-1:0] evt, flg;
  logic [NSRC-1:0] en_q;
  logic            peie_q, gie, take, req;

  ic_edge_detect #(.PORT_W(PORT_W), .PIN_RISE(PIN_RISE)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (pin_i),
    .port_i     (port_i),
    .pin_evt_o  (pin_evt),
    .port_evt_o (port_evt)
  );

  always_comb begin
    evt           = '0;
    evt[SRC_PORT] = port_evt;
    evt[SRC_PIN]  = pin_evt;
    evt[SRC_TMR]  = tmr_ovf_i;
  end

  ic_flag_bank u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .we_i    (csr_we_i),
    .wdata_i (csr_wdata_i[FLG_LSB +: NSRC]),
    .flg_o   (flg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      peie_q <= 1'b0;
    end else if (csr_we_i) begin
      en_q   <= csr_wdata_i[EN_LSB +: NSRC];
      peie_q <= csr_wdata_i[PEIE_BIT];
    end
  end

  assign req = gie & ((|(flg & en_q)) | (peie_q & (|(periph_flag_i & periph_en_i))));

  ic_accept u_accept (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req),
    .we_i     (csr_we_i),
    .wgie_i   (csr_wdata_i[GIE_BIT]),
    .retfie_i (retfie_i),
    .gie_o    (gie),
    .take_o   (take),
    .nop_o    (nop_o)
  );

  always_comb begin
    csr_rdata_o                      = '0;
    csr_rdata_o[GIE_BIT]             = gie;
    csr_rdata_o[PEIE_BIT]            = peie_q;
    csr_rdata_o[EN_LSB +: NSRC]      = en_q;
    csr_rdata_o[FLG_LSB +: NSRC]     = flg;
  end

  assign irq_o      = req;
  assign vec_req_o  = take;
  assign push_ret_o = take;
  assign vec_addr_o = VEC_ADDR;
endmodule

// File: rtl/ic_ctrl_chk.sv
module ic_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tmr_ovf_i,
  input logic       csr_we_i,
  input logic [7:0] csr_wdata_i,
  input logic [7:0] csr_rdata_o,
  input logic       retfie_i,
  input logic       irq_o,
  input logic       vec_req_o,
  input logic       push_ret_o,
  input logic       nop_o
);
  AST_TAKE_AFTER_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_req_o |-> $past(irq_o)); // R6
  AST_TAKE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_req_o |=> !vec_req_o); // R6
  AST_PUSH_WITH_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_ret_o |-> vec_req_o); // R6
  AST_GIE_CLR_ON_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_req_o |=> !csr_rdata_o[7]); // R6
  AST_RETFIE_SETS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retfie_i && !vec_req_o) |=> csr_rdata_o[7]); // R8
  AST_NOP_AFTER_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && !csr_wdata_i[7]) |=> nop_o); // R9
  AST_NOP_NO_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nop_o |-> !vec_req_o); // R9
  AST_NO_IRQ_NO_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_rdata_o[7] |-> !irq_o); // R5
  AST_TMR_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_ovf_i |=> csr_rdata_o[2]); // R10
endmodule

bind ic_ctrl ic_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tmr_ovf_i   (tmr_ovf_i),
  .csr_we_i    (csr_we_i),
  .csr_wdata_i (csr_wdata_i),
  .csr_rdata_o (csr_rdata_o),
  .retfie_i    (retfie_i),
  .irq_o       (irq_o),
  .vec_req_o   (vec_req_o),
  .push_ret_o  (push_ret_o),
  .nop_o       (nop_o)
);

// File: tb/ic_ctrl_tb_top.sv
module ic_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NTAB = 11;
  // {csr, periph_flag, periph_en}
  localparam logic [15:0] VEC_TAB [NTAB] = '{
    16'h00_00, 16'h24_00, 16'hA4_00, 16'h9C_00, 16'h89_00, 16'h92_00,
    16'hC0_22, 16'h80_22, 16'hC0_12, 16'hFF_00, 16'h7F_FF
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pin_i = 1'b0;
  logic [3:0] port_i = '0;
  logic       tmr_ovf_i = 1'b0;
  logic [3:0] periph_flag_i = '0;
  logic [3:0] periph_en_i = '0;
  logic       csr_we_i = 1'b0;
  logic [7:0] csr_wdata_i = '0;
  logic [7:0] csr_rdata_o;
  logic       retfie_i = 1'b0;
  logic       irq_o, vec_req_o, push_ret_o, nop_o;
  logic [12:0] vec_addr_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ic_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .port_i(port_i),
    .tmr_ovf_i(tmr_ovf_i), .periph_flag_i(periph_flag_i),
    .periph_en_i(periph_en_i), .csr_we_i(csr_we_i),
    .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o),
    .retfie_i(retfie_i), .irq_o(irq_o), .vec_req_o(vec_req_o),
    .push_ret_o(push_ret_o), .vec_addr_o(vec_addr_o), .nop_o(nop_o)
  );

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    csr_we_i = 1'b1; csr_wdata_i = d;
    step();
    csr_we_i = 1'b0;
  endtask

  function automatic logic exp_irq(input logic [7:0] c, input logic [3:0] pf, input logic [3:0] pe);
    return c[7] & ((c[5] & c[2]) | (c[4] & c[1]) | (c[3] & c[0]) | (c[6] & (|(pf & pe))));
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    // R1 reset state
    chk("R1", {8'h0, csr_rdata_o}, 16'h0000);
    chk("R1", {12'h0, irq_o, vec_req_o, push_ret_o, nop_o}, 16'h0);
    step(); rst_ni = 1'b1; step();
    chk("R1", {8'h0, csr_rdata_o}, 16'h0000);

    // R2 R5 R11 table
    for (int i = 0; i < NTAB; i++) begin
      periph_flag_i = VEC_TAB[i][7:4];
      periph_en_i   = VEC_TAB[i][3:0];
      wr(VEC_TAB[i][15:8]);
      chk("R2", {8'h0, csr_rdata_o}, {8'h0, VEC_TAB[i][15:8]});
      chk("R5/R11", {15'h0, irq_o},
          {15'h0, exp_irq(VEC_TAB[i][15:8], VEC_TAB[i][7:4], VEC_TAB[i][3:0])});
      wr(8'h00);
      periph_flag_i = '0; periph_en_i = '0;
      step(); step();
    end

    // R3 pin edge sets flag with all enables clear
    pin_i = 1'b1; step(); pin_i = 1'b0;
    chk("R3", {8'h0, csr_rdata_o}, 16'h0002);
    chk("R3", {15'h0, irq_o}, 16'h0);
    step();
    chk("R4 no set on fall", {8'h0, csr_rdata_o}, 16'h0002);
    wr(8'h00);
    // R4 port change and timer
    port_i = 4'b0100; step();
    chk("R4 port", {8'h0, csr_rdata_o}, 16'h0001);
    step();
    chk("R4 port steady", {8'h0, csr_rdata_o}, 16'h0001);
    wr(8'h00);
    tmr_ovf_i = 1'b1; step(); tmr_ovf_i = 1'b0;
    chk("R4 tmr", {8'h0, csr_rdata_o}, 16'h0004);
    wr(8'h00);

    // R6 R7 R8 take and return loop
    wr(8'h90);
    pin_i = 1'b1; step(); pin_i = 1'b0;
    chk("R6 irq", {15'h0, irq_o}, 16'h1);
    chk("R6 no take yet", {15'h0, vec_req_o}, 16'h0);
    step();
    chk("R6 take", {13'h0, vec_req_o, push_ret_o, 1'b0}, 16'h0006);
    chk("R6 addr", {3'h0, vec_addr_o}, 16'h0004);
    step();
    chk("R6 single", {15'h0, vec_req_o}, 16'h0);
    chk("R6/R7 gie clr flag kept", {8'h0, csr_rdata_o}, 16'h0012);
    retfie_i = 1'b1; step(); retfie_i = 1'b0;
    chk("R8", {8'h0, csr_rdata_o}, 16'h0092);
    step();
    chk("R7 refire", {15'h0, vec_req_o}, 16'h1);
    step();
    wr(8'h00);
    step();

    // R9 suppression after clearing write
    wr(8'h92);
    chk("R9 irq", {15'h0, irq_o}, 16'h1);
    wr(8'h12);
    chk("R9 nop", {14'h0, nop_o, vec_req_o}, 16'h0002);
    step();
    chk("R9 still none", {15'h0, vec_req_o}, 16'h0);
    chk("R9 pending", {8'h0, csr_rdata_o}, 16'h0012);
    retfie_i = 1'b1; step(); retfie_i = 1'b0;
    step();
    chk("R9 taken later", {15'h0, vec_req_o}, 16'h1);
    step();
    wr(8'h00);
    step();

    // R10 hw event beats clearing write
    wr(8'h04);
    tmr_ovf_i = 1'b1; csr_we_i = 1'b1; csr_wdata_i = 8'h00;
    step();
    tmr_ovf_i = 1'b0; csr_we_i = 1'b0;
    chk("R10", {8'h0, csr_rdata_o}, 16'h0004);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule